// File: doc/BRIEF.md
# Cursor Control Code Decoder

This block turns a display control character into cursor action pulses. An upstream detector decides that the current 7-bit character is a display control code and raises `dec_en` for that cycle. While `dec_en` is high, the block matches the whole character against nine fixed control codes. One clock later it raises the matching action output for exactly one cycle. The action outputs drive the cursor counters, the screen clearing logic and the audible alarm.

Decoding runs in two stages. A primary stage sorts each code into one of eight classes. Three of the functions (alarm, full clear and line clear) share a single class. A secondary stage separates those three by gating on two bits of the code. The auto-line-feed mode bit is examined in the secondary stage and changes only the meaning of carriage return. All outputs come from registers.

Top module: `cursor_ctl_decode`

## Requirements
- R1: While `dec_en` is low in a cycle, no action output is high in the following cycle, whatever `code` and `auto_lf` carry.
- R2: While `rst` is high at a rising edge, all outputs are low after that edge. An accepted code shows up on its output in the cycle after the edge that samples it, and the output stays high for that one cycle only.
- R3: Code 0x07 pulses `bell`, code 0x08 pulses `x_dec`, and code 0x15 pulses `x_inc`.
- R4: Code 0x0A pulses `y_inc` and code 0x1A pulses `y_dec`.
- R5: Code 0x0D pulses `x_home` alone when `auto_lf` is 0. When `auto_lf` is 1 it pulses `x_home` and `y_inc` together.
- R6: Code 0x16 pulses `line_clr`, code 0x18 pulses `clear_all` (a full clear that also homes X and Y), and code 0x19 pulses `home` (X and Y homed with no clear).
- R7: `auto_lf` has no effect on the outputs for any code except 0x0D.
- R8: Any other 7-bit value produces no output. This includes a listed code with bit 5 or bit 6 set, for example 0x27 or 0x4D.
- R9: In any cycle, at most one action output is high. The one exception is the `x_home` plus `y_inc` pair from R5.
- R10: When `dec_en` stays high with a new code on every cycle, each code gives its own pulse on consecutive cycles, with no gaps and no merging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | High when the current character is a display control code |
| code | input | 7 | Character to decode |
| auto_lf | input | 1 | Auto-line-feed mode bit |
| bell | output | 1 | Sound alarm pulse |
| x_dec | output | 1 | Move cursor left pulse |
| x_inc | output | 1 | Move cursor right pulse |
| y_inc | output | 1 | Move cursor down pulse |
| y_dec | output | 1 | Move cursor up pulse |
| x_home | output | 1 | Return X to the first column pulse |
| line_clr | output | 1 | Clear the current line pulse |
| clear_all | output | 1 | Clear the screen and home X and Y pulse |
| home | output | 1 | Home X and Y pulse |

## Verification
Four rules hold on every cycle and are checked there: the outputs stay quiet after a disabled cycle or a reset, at most one output is high (or the single allowed pair), a paired return-and-line-feed only ever follows a set mode bit, and characters with either upper bit set are rejected. Only the bench scenarios can show that each listed code reaches its own output and not some other one. The same holds for the claim that the mode bit leaves every other code unchanged, that near-miss values stay silent, and that back-to-back codes come out in order, one per cycle.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int CODE_W = 7;
    typedef logic [CODE_W-1:0] cc_code_t;

    localparam cc_code_t C_BEL = 7'h07;
    localparam cc_code_t C_BS  = 7'h08;
    localparam cc_code_t C_LF  = 7'h0A;
    localparam cc_code_t C_CR  = 7'h0D;
    localparam cc_code_t C_NAK = 7'h15;
    localparam cc_code_t C_SYN = 7'h16;
    localparam cc_code_t C_CAN = 7'h18;
    localparam cc_code_t C_EM  = 7'h19;
    localparam cc_code_t C_SUB = 7'h1A;

    // Eight primary classes; alarm, line clear and full clear share PC_SHARED.
    typedef enum logic [2:0] {
        PC_NONE,
        PC_XDEC,
        PC_YINC,
        PC_RET,
        PC_XINC,
        PC_HOME,
        PC_YDEC,
        PC_SHARED
    } cc_class_e;

    typedef struct packed {
        logic bell;
        logic x_dec;
        logic x_inc;
        logic y_inc;
        logic y_dec;
        logic x_home;
        logic line_clr;
        logic clear_all;
        logic home;
    } cc_act_t;

    localparam int ACT_W = $bits(cc_act_t);

    function automatic cc_class_e cc_classify(input cc_code_t c);
        cc_class_e k;
        case (c)
            C_BS:                k = PC_XDEC;
            C_LF:                k = PC_YINC;
            C_CR:                k = PC_RET;
            C_NAK:               k = PC_XINC;
            C_EM:                k = PC_HOME;
            C_SUB:               k = PC_YDEC;
            C_BEL, C_SYN, C_CAN: k = PC_SHARED;
            default:             k = PC_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cc_primary_decode.sv
module cc_primary_decode
    import cc_pkg::*;
(
    input  logic      en,
    input  cc_code_t  code,
    output cc_class_e cls
);

    always_comb begin
        if (en) cls = cc_classify(code);
        else    cls = PC_NONE;
    end

endmodule

// File: rtl/cc_secondary_split.sv
module cc_secondary_split
    import cc_pkg::*;
(
    input  cc_class_e cls,
    input  cc_code_t  code,
    input  logic      auto_lf,
    output cc_act_t   act
);

    // Within the shared class: bit 4 low means alarm; otherwise bit 3 picks
    // full clear (set) or line clear (clear).
    logic shared_hit;
    assign shared_hit = (cls == PC_SHARED);

    always_comb begin
        act           = '0;
        act.bell      = shared_hit && !code[4];
        act.clear_all = shared_hit &&  code[4] &&  code[3];
        act.line_clr  = shared_hit &&  code[4] && !code[3];
        act.x_dec     = (cls == PC_XDEC);
        act.x_inc     = (cls == PC_XINC);
        act.y_dec     = (cls == PC_YDEC);
        act.home      = (cls == PC_HOME);
        act.x_home    = (cls == PC_RET);
        act.y_inc     = (cls == PC_YINC) || ((cls == PC_RET) && auto_lf);
    end

endmodule

// File: rtl/cc_pulse_reg.sv
module cc_pulse_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= d[i];
        end
    end

endmodule

// File: rtl/cursor_ctl_decode.sv
module cursor_ctl_decode
    import cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dec_en,
    input  logic [6:0] code,
    input  logic       auto_lf,
    output logic       bell,
    output logic       x_dec,
    output logic       x_inc,
    output logic       y_inc,
    output logic       y_dec,
    output logic       x_home,
    output logic       line_clr,
    output logic       clear_all,
    output logic       home
);

    cc_class_e cls;
    cc_act_t   act_d;
    cc_act_t   act_q;
    logic [ACT_W-1:0] act_bits;

    cc_primary_decode u_pri (
        .en   (dec_en),
        .code (code),
        .cls  (cls)
    );

    cc_secondary_split u_sec (
        .cls     (cls),
        .code    (code),
        .auto_lf (auto_lf),
        .act     (act_d)
    );

    cc_pulse_reg #(.W(ACT_W)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (act_d),
        .q   (act_bits)
    );

    assign act_q     = cc_act_t'(act_bits);
    assign bell      = act_q.bell;
    assign x_dec     = act_q.x_dec;
    assign x_inc     = act_q.x_inc;
    assign y_inc     = act_q.y_inc;
    assign y_dec     = act_q.y_dec;
    assign x_home    = act_q.x_home;
    assign line_clr  = act_q.line_clr;
    assign clear_all = act_q.clear_all;
    assign home      = act_q.home;

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !dec_en |=> (act_bits == '0));

    a_r2_reset_clears: assert property (@(posedge clk)
        rst |=> (act_bits == '0));

    a_r5_return_pairs: assert property (@(posedge clk) disable iff (rst)
        (dec_en && code == C_CR && auto_lf) |=> (x_home && y_inc));

    a_r7_pair_needs_mode: assert property (@(posedge clk) disable iff (rst)
        (x_home && y_inc) |-> $past(auto_lf));

    a_r8_upper_bits_reject: assert property (@(posedge clk) disable iff (rst)
        (dec_en && code[6:5] != 2'b00) |=> (act_bits == '0));

    a_r9_one_action: assert property (@(posedge clk) disable iff (rst)
        ($countones(act_bits) <= 1) ||
        ($countones(act_bits) == 2 && x_home && y_inc));

endmodule

// File: tb/tb_cursor_ctl_decode.sv
module tb_cursor_ctl_decode;

    typedef struct {
        logic [8:0] v;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_en = 1'b0;
    logic [6:0] code = '0;
    logic       auto_lf = 1'b0;
    logic bell, x_dec, x_inc, y_inc, y_dec, x_home, line_clr, clear_all, home;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t exp_q[$];

    always #10ns clk = ~clk;

    cursor_ctl_decode dut (
        .clk(clk), .rst(rst), .dec_en(dec_en), .code(code), .auto_lf(auto_lf),
        .bell(bell), .x_dec(x_dec), .x_inc(x_inc), .y_inc(y_inc), .y_dec(y_dec),
        .x_home(x_home), .line_clr(line_clr), .clear_all(clear_all), .home(home)
    );

    function automatic logic [8:0] outs();
        return {bell, x_dec, x_inc, y_inc, y_dec, x_home, line_clr, clear_all, home};
    endfunction

    // Order: bell x_dec x_inc y_inc y_dec x_home line_clr clear_all home
    function automatic logic [8:0] model(logic en, logic [6:0] c, logic alf);
        logic [8:0] e = '0;
        if (en) begin
            case (c)
                7'h07: e[8] = 1'b1;
                7'h08: e[7] = 1'b1;
                7'h15: e[6] = 1'b1;
                7'h0A: e[5] = 1'b1;
                7'h1A: e[4] = 1'b1;
                7'h0D: begin e[3] = 1'b1; e[5] = alf; end
                7'h16: e[2] = 1'b1;
                7'h18: e[1] = 1'b1;
                7'h19: e[0] = 1'b1;
                default: e = '0;
            endcase
        end
        return e;
    endfunction

    task automatic check(logic [8:0] act, logic [8:0] exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b, expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(logic en, logic [6:0] c, logic alf, string tag);
        exp_t e;
        @(negedge clk);
        dec_en  = en;
        code    = c;
        auto_lf = alf;
        e.v   = model(en, c, alf);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: each item is registered at the next rising edge; sample mid-high phase.
    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            #5ns;
            check(outs(), e.v, e.tag);
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [6:0] listed [9];
        logic [6:0] misses [6];
        listed = '{7'h07, 7'h08, 7'h15, 7'h0A, 7'h1A, 7'h0D, 7'h16, 7'h18, 7'h19};
        misses = '{7'h00, 7'h27, 7'h4D, 7'h1F, 7'h0C, 7'h7A};

        // R2: reset state, with a code presented during reset
        dec_en = 1'b1;
        code   = 7'h07;
        repeat (3) @(posedge clk);
        #5ns;
        check(outs(), 9'b0, "R2 reset");
        @(negedge clk);
        rst = 1'b0;
        dec_en = 1'b0;

        // R3 R4 R5 R6: each listed code, separated by idle cycles (R2 single-cycle pulse)
        drive(1'b1, 7'h07, 1'b0, "R3 bell");   drive(1'b0, 7'h07, 1'b0, "R2 pulse ends");
        drive(1'b1, 7'h08, 1'b0, "R3 x_dec");  drive(1'b0, 7'h00, 1'b0, "R2 pulse ends");
        drive(1'b1, 7'h15, 1'b0, "R3 x_inc");  drive(1'b0, 7'h00, 1'b0, "R2 pulse ends");
        drive(1'b1, 7'h0A, 1'b0, "R4 y_inc");  drive(1'b0, 7'h00, 1'b0, "R2 pulse ends");
        drive(1'b1, 7'h1A, 1'b0, "R4 y_dec");  drive(1'b0, 7'h00, 1'b0, "R2 pulse ends");
        drive(1'b1, 7'h0D, 1'b0, "R5 return"); drive(1'b0, 7'h00, 1'b0, "R2 pulse ends");
        drive(1'b1, 7'h0D, 1'b1, "R5 return with line feed");
        drive(1'b0, 7'h00, 1'b0, "R2 pulse ends");
        drive(1'b1, 7'h16, 1'b0, "R6 line_clr");  drive(1'b0, 7'h00, 1'b0, "R2 pulse ends");
        drive(1'b1, 7'h18, 1'b0, "R6 clear_all"); drive(1'b0, 7'h00, 1'b0, "R2 pulse ends");
        drive(1'b1, 7'h19, 1'b0, "R6 home");      drive(1'b0, 7'h00, 1'b0, "R2 pulse ends");

        // R7: mode bit set on every listed code
        foreach (listed[i]) drive(1'b1, listed[i], 1'b1, "R7 mode bit");

        // R1: enable low with listed codes and either mode value
        foreach (listed[i]) drive(1'b0, listed[i], listed[i][0], "R1 disabled");

        // R8: unlisted and near-miss values
        foreach (misses[i]) begin
            drive(1'b1, misses[i], 1'b0, "R8 unlisted");
            drive(1'b1, misses[i], 1'b1, "R8 unlisted");
        end

        // R10 and R9: back-to-back codes, alternating mode bit
        for (int r = 0; r < 3; r++) begin
            foreach (listed[i]) drive(1'b1, listed[i], logic'((i + r) % 2), "R10 back-to-back");
        end

        drive(1'b0, 7'h00, 1'b0, "R1 idle");
        repeat (3) @(posedge clk);
        #5ns;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule